// File: doc/BRIEF.md
# LPC Flash Target Bus Controller

This block is the bus-facing state machine of a flash target on a four-bit LPC-style bus. It follows the host through each memory cycle one nibble per clock, collects the address and any write data, and turns the bus around for the target's reply. A read is answered with a SYNC nibble and then the stored byte. A write becomes a one-cycle command strobe to the program/erase engine, carrying the address and the byte. The strobe is raised as soon as the second data nibble has arrived. The flash array itself sits outside the block. Reads fetch a byte through `memAddr`/`rdData`, and the array reports through `arrBusy` while it is working.

Two separate active-low reset pins both hold the block in reset. Reset floats the bus, deselects the target, and signals the array to abandon any program or erase in progress. On release, the block goes back to idle (read mode) and pulses a request that reloads the lock registers with their defaults. Write protection is checked per block. Each block's lock bit can protect it, and two override pins can also force protection: one covers the top block and the other covers all remaining blocks. A protected write still completes on the bus, but it never reaches the command interface.

Top module: `lpcFlashTarget`

## Requirements
- R1: While `ifRstN` or `cpuRstN` is low, `ladOe` and `cmdStrobe` are 0 and `peAbort` is 1, even in the middle of a cycle. Releasing only one of the two pins keeps the block in reset.
- R2: In the first clock cycle after both reset pins are high, `lockRestore` is 1 for exactly one cycle. The block is then idle and accepts a new read.
- R3: A cycle begins when `frameN` is low and `ladIn` is 0000 at a clock edge. The following nibble selects a memory read (0100) or a memory write (0110). Any other start nibble, and any other type nibble, leaves the block idle without driving LAD.
- R4: A read takes eight address nibbles, most significant first, followed by two host turnaround cycles. The target then drives SYNC 0000, the low nibble of `rdData`, the high nibble, and 1111, and floats LAD in the next cycle. `memAddr` holds the low MEM_AW bits of the address.
- R5: While `arrBusy` is 1 in the SYNC slot, the target drives 0101 and repeats the SYNC slot. It moves on only once `arrBusy` is 0.
- R6: In a write, the two data nibbles follow the address, low nibble first. `cmdStrobe` is 1 for exactly one cycle, in the cycle right after the second data nibble, with `cmdData` = {high, low} and `memAddr` holding the address. The reply is two host turnaround cycles, SYNC, 1111, and then float.
- R7: The block index is `memAddr[MEM_AW-1 -: BLK_W]`, and the top block is the all-ones index. The top block is protected when `topLockN` is 0. Every other block is protected when `wrProtN` is 0. Any block whose `lockBits` bit is 1 is protected. A write to a protected block completes on the bus with no `cmdStrobe`.
- R8: If `frameN` goes low in any non-idle cycle, `ladOe` drops in that same cycle and the block returns to idle. A write aborted before or on its second data nibble raises no strobe.
- R9: An abort in the final turnaround of a write floats the bus at once, but the strobe already issued for that write still counts.
- R10: While idle with `frameN` high, the block never drives LAD or raises `cmdStrobe`, whatever is on `ladIn`.
- R11: The target never drives LAD during the two turnaround cycles owned by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| ifRstN | input | 1 | Interface reset, active low |
| cpuRstN | input | 1 | Processor reset, active low |
| frameN | input | 1 | Cycle framing, active low; low during a cycle aborts it |
| ladIn | input | 4 | Nibble received from the bus |
| ladOut | output | 4 | Nibble driven by the target |
| ladOe | output | 1 | Output enable for `ladOut` |
| topLockN | input | 1 | Forces protection of the top block when low |
| wrProtN | input | 1 | Forces protection of all other blocks when low |
| lockBits | input | 2**BLK_W | Per-block lock register state, 1 = locked |
| arrBusy | input | 1 | Array busy; stretches SYNC |
| rdData | input | 8 | Byte read from the array at `memAddr` |
| memAddr | output | MEM_AW | Array address for reads and commands |
| cmdStrobe | output | 1 | One-cycle command strobe for an accepted write |
| cmdData | output | 8 | Write byte carried with the strobe |
| peAbort | output | 1 | Tells the array to abandon program/erase (high in reset) |
| lockRestore | output | 1 | One-cycle request to reload lock register defaults |

## Verification
The bench builds the block with MEM_AW = 8 and BLK_W = 2. With those values a 256-byte array model and four blocks are enough to reach the top block, a middle block and block zero using single-byte addresses. That puts every combination of the two override pins and the lock bits within a few cycles of each other. The address stays eight nibbles long, so the full shift path is exercised and truncation to the low bits is visible. Aborts are placed in the address, in the second data nibble, in read data and in the final write turnaround, and a reset is placed mid-read, to cover the asymmetric cancellation rules.

// File: rtl/lpcFlashPkg.sv
package lpcFlashPkg;

  localparam logic [3:0] NIB_START     = 4'h0;
  localparam logic [3:0] NIB_MEM_RD    = 4'h4;
  localparam logic [3:0] NIB_MEM_WR    = 4'h6;
  localparam logic [3:0] NIB_SYNC_OK   = 4'h0;
  localparam logic [3:0] NIB_SYNC_WAIT = 4'h5;
  localparam logic [3:0] NIB_TAR       = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_WDAT,
    ST_HTAR0,
    ST_HTAR1,
    ST_SYNC,
    ST_RDAT,
    ST_TTAR0,
    ST_TTAR1
  } busState_e;

  typedef enum logic [2:0] {
    OUT_SYNC_OK,
    OUT_SYNC_WAIT,
    OUT_DATA_LO,
    OUT_DATA_HI,
    OUT_ONES
  } outSel_e;

  typedef struct packed {
    logic    shiftAddr;
    logic    capLo;
    logic    capHi;
    logic    drive;
    outSel_e sel;
  } dpCtl_t;

endpackage

// File: rtl/lpcCtrl.sv
module lpcCtrl
  import lpcFlashPkg::*;
#(
  parameter int ADDR_NIB = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] ladIn,
  input  logic       arrBusy,
  input  logic       protHit,
  output dpCtl_t     ctl,
  output logic       cmdStrobe,
  output logic       lockRestore
);

  localparam int CNT_W = (ADDR_NIB > 2) ? $clog2(ADDR_NIB) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  busState_e       stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic            isWrQ, isWrD;
  logic            strobeD;
  logic            restorePend;
  logic            abortNow;

  assign abortNow = (stateQ != ST_IDLE) && !frameN;

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    isWrD   = isWrQ;
    strobeD = 1'b0;
    ctl     = '0;
    ctl.sel = OUT_ONES;
    unique case (stateQ)
      ST_IDLE: begin
        if (!frameN && ladIn == NIB_START) stateD = ST_TYPE;
      end
      ST_TYPE: begin
        cntD = '0;
        if (ladIn == NIB_MEM_RD) begin
          isWrD  = 1'b0;
          stateD = ST_ADDR;
        end else if (ladIn == NIB_MEM_WR) begin
          isWrD  = 1'b1;
          stateD = ST_ADDR;
        end else begin
          stateD = ST_IDLE;
        end
      end
      ST_ADDR: begin
        ctl.shiftAddr = 1'b1;
        if (cntQ == ADDR_LAST) begin
          cntD   = '0;
          stateD = isWrQ ? ST_WDAT : ST_HTAR0;
        end else begin
          cntD = cntQ + ONE;
        end
      end
      ST_WDAT: begin
        if (cntQ == ONE) begin
          ctl.capHi = 1'b1;
          strobeD   = !protHit;
          cntD      = '0;
          stateD    = ST_HTAR0;
        end else begin
          ctl.capLo = 1'b1;
          cntD      = ONE;
        end
      end
      ST_HTAR0: stateD = ST_HTAR1;
      ST_HTAR1: stateD = ST_SYNC;
      ST_SYNC: begin
        ctl.drive = 1'b1;
        ctl.sel   = arrBusy ? OUT_SYNC_WAIT : OUT_SYNC_OK;
        if (!arrBusy) begin
          cntD   = '0;
          stateD = isWrQ ? ST_TTAR0 : ST_RDAT;
        end
      end
      ST_RDAT: begin
        ctl.drive = 1'b1;
        if (cntQ == ONE) begin
          ctl.sel = OUT_DATA_HI;
          cntD    = '0;
          stateD  = ST_TTAR0;
        end else begin
          ctl.sel = OUT_DATA_LO;
          cntD    = ONE;
        end
      end
      ST_TTAR0: begin
        ctl.drive = 1'b1;
        ctl.sel   = OUT_ONES;
        stateD    = ST_TTAR1;
      end
      ST_TTAR1: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
    if (abortNow) begin
      stateD        = ST_IDLE;
      strobeD       = 1'b0;
      ctl.shiftAddr = 1'b0;
      ctl.capLo     = 1'b0;
      ctl.capHi     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      cntQ        <= '0;
      isWrQ       <= 1'b0;
      cmdStrobe   <= 1'b0;
      restorePend <= 1'b1;
      lockRestore <= 1'b0;
    end else begin
      stateQ      <= stateD;
      cntQ        <= cntD;
      isWrQ       <= isWrD;
      cmdStrobe   <= strobeD;
      lockRestore <= restorePend;
      restorePend <= 1'b0;
    end
  end

  AST_RESTORE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    lockRestore |=> !lockRestore); // R2

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SYNC && arrBusy && frameN) |=> stateQ == ST_SYNC); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe); // R6

  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WDAT && cntQ == ONE && protHit) |=> !cmdStrobe); // R7

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && !frameN) |=> stateQ == ST_IDLE); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_IDLE |-> !ctl.drive); // R10

  AST_HOST_TAR: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HTAR0 || stateQ == ST_HTAR1) |-> !ctl.drive); // R11

endmodule

// File: rtl/lpcDatapath.sv
module lpcDatapath
  import lpcFlashPkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int BLK_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           ladIn,
  input  dpCtl_t               ctl,
  input  logic [7:0]           rdData,
  input  logic                 topLockN,
  input  logic                 wrProtN,
  input  logic [(1<<BLK_W)-1:0] lockBits,
  output logic [3:0]           ladOut,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [7:0]           cmdData,
  output logic                 protHit
);

  localparam int NUM_BLK = 1 << BLK_W;
  localparam int TOP_BLK = NUM_BLK - 1;

  logic [MEM_AW-1:0]  addrQ;
  logic [7:0]         dataQ;
  logic [BLK_W-1:0]   blkIdx;
  logic [NUM_BLK-1:0] blkProt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (ctl.shiftAddr) addrQ <= MEM_AW'({addrQ, ladIn});
      if (ctl.capLo) dataQ[3:0] <= ladIn;
      if (ctl.capHi) dataQ[7:4] <= ladIn;
    end
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : gProt
    if (g == TOP_BLK) begin : gTop
      assign blkProt[g] = lockBits[g] | ~topLockN;
    end else begin : gRest
      assign blkProt[g] = lockBits[g] | ~wrProtN;
    end
  end

  assign blkIdx  = addrQ[MEM_AW-1 -: BLK_W];
  assign protHit = blkProt[blkIdx];
  assign memAddr = addrQ;
  assign cmdData = dataQ;

  always_comb begin
    unique case (ctl.sel)
      OUT_SYNC_OK:   ladOut = NIB_SYNC_OK;
      OUT_SYNC_WAIT: ladOut = NIB_SYNC_WAIT;
      OUT_DATA_LO:   ladOut = rdData[3:0];
      OUT_DATA_HI:   ladOut = rdData[7:4];
      default:       ladOut = NIB_TAR;
    endcase
  end

endmodule

// File: rtl/lpcFlashTarget.sv
module lpcFlashTarget
  import lpcFlashPkg::*;
#(
  parameter int ADDR_NIB = 8,
  parameter int MEM_AW   = 16,
  parameter int BLK_W    = 3
) (
  input  logic                  clk,
  input  logic                  ifRstN,
  input  logic                  cpuRstN,
  input  logic                  frameN,
  input  logic [3:0]            ladIn,
  output logic [3:0]            ladOut,
  output logic                  ladOe,
  input  logic                  topLockN,
  input  logic                  wrProtN,
  input  logic [(1<<BLK_W)-1:0] lockBits,
  input  logic                  arrBusy,
  input  logic [7:0]            rdData,
  output logic [MEM_AW-1:0]     memAddr,
  output logic                  cmdStrobe,
  output logic [7:0]            cmdData,
  output logic                  peAbort,
  output logic                  lockRestore
);

  logic   rstN;
  logic   protHit;
  dpCtl_t ctl;

  assign rstN    = ifRstN & cpuRstN;
  assign peAbort = ~rstN;
  assign ladOe   = ctl.drive & frameN & rstN;

  lpcCtrl #(.ADDR_NIB(ADDR_NIB)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameN      (frameN),
    .ladIn       (ladIn),
    .arrBusy     (arrBusy),
    .protHit     (protHit),
    .ctl         (ctl),
    .cmdStrobe   (cmdStrobe),
    .lockRestore (lockRestore)
  );

  lpcDatapath #(.MEM_AW(MEM_AW), .BLK_W(BLK_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ladIn    (ladIn),
    .ctl      (ctl),
    .rdData   (rdData),
    .topLockN (topLockN),
    .wrProtN  (wrProtN),
    .lockBits (lockBits),
    .ladOut   (ladOut),
    .memAddr  (memAddr),
    .cmdData  (cmdData),
    .protHit  (protHit)
  );

endmodule

// File: tb/lpcFlashTarget_bench.sv
module lpcFlashTarget_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;
  localparam int BLK_W      = 2;
  localparam int NUM_BLK    = 1 << BLK_W;

  logic clk = 1'b0;
  logic ifRstN, cpuRstN, frameN, topLockN, wrProtN, arrBusy;
  logic [3:0] ladIn, ladOut;
  logic ladOe, cmdStrobe, peAbort, lockRestore;
  logic [NUM_BLK-1:0] lockBits;
  logic [7:0] rdData, cmdData;
  logic [MEM_AW-1:0] memAddr;

  logic [7:0] mem [1<<MEM_AW];

  int checks = 0;
  int failures = 0;
  int strobeSeen = 0;
  int cycles = 0;
  bit running = 0;

  // behavioural reference state
  int          mPos = 0;
  bit          mWr = 0;
  logic [31:0] mAddr = '0;
  logic [7:0]  mDat = '0;
  bit          mStrobe = 0;
  bit          mPend = 1;
  bit          mRestore = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpcFlashTarget #(.ADDR_NIB(8), .MEM_AW(MEM_AW), .BLK_W(BLK_W)) u_lpcFlashTarget (
    .clk(clk), .ifRstN(ifRstN), .cpuRstN(cpuRstN), .frameN(frameN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .topLockN(topLockN), .wrProtN(wrProtN),
    .lockBits(lockBits), .arrBusy(arrBusy), .rdData(rdData), .memAddr(memAddr),
    .cmdStrobe(cmdStrobe), .cmdData(cmdData), .peAbort(peAbort), .lockRestore(lockRestore)
  );

  assign rdData = mem[memAddr];

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) if (cmdStrobe) mem[memAddr] <= cmdData;

  function automatic bit isProt(input logic [31:0] a);
    int blk;
    blk = int'(a[MEM_AW-1 -: BLK_W]);
    if (lockBits[blk]) return 1;
    if (blk == NUM_BLK - 1) return !topLockN;
    return !wrProtN;
  endfunction

  function automatic int syncPos(input bit w);
    return w ? 14 : 12;
  endfunction

  // reference model: advances one bus nibble per clock
  always @(posedge clk) begin
    if (!(ifRstN && cpuRstN)) begin
      mPos = 0; mStrobe = 0; mPend = 1; mRestore = 0;
    end else begin
      bit nxt;
      nxt = 0;
      mRestore = mPend;
      mPend = 0;
      if (mPos == 0) begin
        if (!frameN && ladIn == 4'h0) mPos = 1;
      end else if (!frameN) begin
        mPos = 0;
      end else if (mPos == 1) begin
        if (ladIn == 4'h4) begin mWr = 0; mPos = 2; end
        else if (ladIn == 4'h6) begin mWr = 1; mPos = 2; end
        else mPos = 0;
      end else if (mPos <= 9) begin
        mAddr = {mAddr[27:0], ladIn};
        mPos++;
      end else if (mWr && mPos == 10) begin
        mDat[3:0] = ladIn; mPos++;
      end else if (mWr && mPos == 11) begin
        mDat[7:4] = ladIn; nxt = !isProt(mAddr); mPos++;
      end else if (mPos == syncPos(mWr)) begin
        if (!arrBusy) mPos++;
      end else if (mPos == 16) begin
        mPos = 0;
      end else begin
        mPos++;
      end
      mStrobe = nxt;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the clock edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (running) begin
      bit rstOk, drv;
      logic [3:0] eOut;
      logic [7:0] b;
      rstOk = ifRstN && cpuRstN;
      b = mem[mAddr[MEM_AW-1:0]];
      drv = 0; eOut = 4'hF;
      if (mPos == syncPos(mWr)) begin drv = 1; eOut = arrBusy ? 4'h5 : 4'h0; end
      else if (!mWr && mPos == 13) begin drv = 1; eOut = b[3:0]; end
      else if (!mWr && mPos == 14) begin drv = 1; eOut = b[7:4]; end
      else if (mPos == 15) begin drv = 1; eOut = 4'hF; end
      drv = drv && rstOk && frameN;
      chk(ladOe == drv, "R4", "ladOe", 32'(ladOe), 32'(drv));
      if (drv) chk(ladOut == eOut, "R4", "ladOut", 32'(ladOut), 32'(eOut));
      chk(cmdStrobe == (rstOk && mStrobe), "R6", "cmdStrobe", 32'(cmdStrobe), 32'(rstOk && mStrobe));
      if (rstOk && mStrobe) begin
        chk(cmdData == mDat, "R6", "cmdData", 32'(cmdData), 32'(mDat));
        chk(memAddr == mAddr[MEM_AW-1:0], "R6", "memAddr", 32'(memAddr), 32'(mAddr[MEM_AW-1:0]));
      end
      chk(lockRestore == (rstOk && mRestore), "R2", "lockRestore", 32'(lockRestore), 32'(rstOk && mRestore));
      chk(peAbort == !rstOk, "R1", "peAbort", 32'(peAbort), 32'(!rstOk));
      if (cmdStrobe) strobeSeen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL R4 watchdog actual=%0d expected=<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drv(input logic fr, input logic [3:0] n, input logic b);
    @(negedge clk);
    frameN = fr; ladIn = n; arrBusy = b;
  endtask

  // one bus cycle; cutPos >= 0 interrupts it at that nibble (abort or reset)
  task automatic runCycle(input bit isWr, input logic [31:0] addr, input logic [7:0] data,
                          input int waits, input int cutPos, input bit byReset,
                          output logic [7:0] rdByte);
    rdByte = 8'h00;
    for (int p = 0; p <= 16; p++) begin
      logic fr;
      logic [3:0] n;
      fr = 1'b1; n = 4'hF;
      if (p == 0) begin fr = 1'b0; n = 4'h0; end
      else if (p == 1) n = isWr ? 4'h6 : 4'h4;
      else if (p <= 9) n = addr[31 - 4*(p-2) -: 4];
      else if (isWr && p == 10) n = data[3:0];
      else if (isWr && p == 11) n = data[7:4];
      if (p == cutPos) begin
        if (byReset) begin
          @(negedge clk);
          cpuRstN = 1'b0; frameN = 1'b1; ladIn = 4'hF;
          #(CLK_PERIOD/4);
          chk(ladOe == 1'b0, "R1", "ladOe in reset", 32'(ladOe), 0);
          chk(peAbort == 1'b1, "R1", "peAbort in reset", 32'(peAbort), 1);
          drv(1, 4'hF, 0); drv(1, 4'hF, 0);
          @(negedge clk); cpuRstN = 1'b1;
          @(posedge clk); #(CLK_PERIOD/4);
          chk(lockRestore == 1'b1, "R2", "restore pulse", 32'(lockRestore), 1);
        end else begin
          drv(1'b0, 4'hF, 0);
          #(CLK_PERIOD/4);
          chk(ladOe == 1'b0, "R8", "ladOe on abort", 32'(ladOe), 0);
          drv(1, 4'hF, 0); drv(1, 4'hF, 0);
        end
        return;
      end
      if (p == syncPos(isWr)) begin
        for (int w = 0; w < waits; w++) drv(1, 4'hF, 1);
        drv(1, 4'hF, 0);
      end else begin
        drv(fr, n, 0);
      end
      #(CLK_PERIOD/4);
      if ((!isWr && (p == 10 || p == 11)) || (isWr && (p == 12 || p == 13)))
        chk(ladOe == 1'b0, "R11", "host turnaround drive", 32'(ladOe), 0);
      if (!isWr && p == 13) rdByte[3:0] = ladOut;
      if (!isWr && p == 14) rdByte[7:4] = ladOut;
    end
    drv(1, 4'hF, 0);
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [7:0] d);
    logic [7:0] unused;
    runCycle(1, a, d, 0, -1, 0, unused);
  endtask

  task automatic doRead(input logic [31:0] a, input int waits, output logic [7:0] v);
    runCycle(0, a, 8'h00, waits, -1, 0, v);
  endtask

  initial begin
    logic [7:0] v;
    int base;
    ifRstN = 0; cpuRstN = 0; frameN = 1; ladIn = 4'hF; arrBusy = 0;
    topLockN = 1; wrProtN = 1; lockBits = '0;
    running = 1;
    repeat (3) drv(1, 4'hF, 0);
    #(CLK_PERIOD/4);
    chk(ladOe == 0 && cmdStrobe == 0 && peAbort == 1, "R1", "reset state",
        {ladOe, cmdStrobe, peAbort}, 3'b001);
    @(negedge clk); ifRstN = 1;
    #(CLK_PERIOD/4);
    chk(peAbort == 1, "R1", "one pin still low", 32'(peAbort), 1);
    @(negedge clk); cpuRstN = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(lockRestore == 1, "R2", "restore after release", 32'(lockRestore), 1);
    @(posedge clk); #(CLK_PERIOD/4);
    chk(lockRestore == 0, "R2", "restore one cycle", 32'(lockRestore), 0);

    // plain write then read back
    base = strobeSeen;
    doWrite(32'h0000_0010, 8'h12);
    chk(strobeSeen == base + 1, "R6", "strobe count", strobeSeen, base + 1);
    doRead(32'h0000_0010, 0, v);
    chk(v == 8'h12, "R4", "read back", v, 8'h12);
    doRead(32'hABCD_00C5, 0, v);
    chk(v == 8'(197*7+3), "R4", "read high addr bits", v, 8'(197*7+3));

    // busy stretches SYNC
    doRead(32'h0000_0033, 3, v);
    chk(v == 8'(51*7+3), "R5", "read after busy", v, 8'(51*7+3));
    doWrite(32'h0000_0034, 8'h9A);
    begin
      logic [7:0] unused;
      runCycle(1, 32'h0000_0035, 8'h5C, 4, -1, 0, unused);
    end
    doRead(32'h0000_0035, 0, v);
    chk(v == 8'h5C, "R5", "busy write landed", v, 8'h5C);

    // bad start and bad type nibbles
    base = strobeSeen;
    drv(0, 4'h3, 0); drv(1, 4'h6, 0);
    for (int k = 0; k < 10; k++) begin
      drv(1, 4'h0, 0); #(CLK_PERIOD/4);
      chk(ladOe == 0, "R3", "bad start idle", 32'(ladOe), 0);
    end
    drv(0, 4'h0, 0); drv(1, 4'h2, 0);
    for (int k = 0; k < 12; k++) begin
      drv(1, 4'h1, 0); #(CLK_PERIOD/4);
      chk(ladOe == 0, "R3", "bad type idle", 32'(ladOe), 0);
    end
    chk(strobeSeen == base, "R3", "no strobe", strobeSeen, base);

    // standby: frame high, arbitrary LAD
    for (int k = 0; k < 8; k++) begin
      drv(1, 4'(k), 0); #(CLK_PERIOD/4);
      chk(ladOe == 0 && cmdStrobe == 0, "R10", "standby quiet", {ladOe, cmdStrobe}, 0);
    end

    // protection
    wrProtN = 0;
    base = strobeSeen;
    doWrite(32'h0000_0020, 8'h55);
    chk(strobeSeen == base, "R7", "wrProt blk0", strobeSeen, base);
    doRead(32'h0000_0020, 0, v);
    chk(v == 8'(32*7+3), "R7", "blk0 unchanged", v, 8'(32*7+3));
    doWrite(32'h0000_00F0, 8'hA1);
    chk(strobeSeen == base + 1, "R7", "top not under wrProt", strobeSeen, base + 1);
    wrProtN = 1; topLockN = 0;
    base = strobeSeen;
    doWrite(32'h0000_00F1, 8'hB2);
    chk(strobeSeen == base, "R7", "top locked", strobeSeen, base);
    doWrite(32'h0000_0021, 8'hC3);
    chk(strobeSeen == base + 1, "R7", "blk0 free under topLock", strobeSeen, base + 1);
    topLockN = 1; lockBits = 4'b0010;
    base = strobeSeen;
    doWrite(32'h0000_0044, 8'hD4);
    chk(strobeSeen == base, "R7", "lock bit blk1", strobeSeen, base);
    doWrite(32'h0000_0084, 8'hE5);
    chk(strobeSeen == base + 1, "R7", "blk2 free", strobeSeen, base + 1);
    lockBits = '0;

    // aborts
    base = strobeSeen;
    runCycle(0, 32'h0000_0050, 8'h00, 0, 5, 0, v);
    runCycle(0, 32'h0000_0050, 8'h00, 0, 13, 0, v);
    runCycle(1, 32'h0000_0060, 8'h77, 0, 11, 0, v);
    chk(strobeSeen == base, "R8", "abort before data done", strobeSeen, base);
    doRead(32'h0000_0060, 0, v);
    chk(v == 8'(96*7+3), "R8", "aborted write absent", v, 8'(96*7+3));
    base = strobeSeen;
    runCycle(1, 32'h0000_0061, 8'h88, 0, 15, 0, v);
    chk(strobeSeen == base + 1, "R9", "late abort keeps command", strobeSeen, base + 1);
    doRead(32'h0000_0061, 0, v);
    chk(v == 8'h88, "R9", "late abort data", v, 8'h88);

    // reset in the middle of a read, then read mode again
    runCycle(0, 32'h0000_0010, 8'h00, 0, 13, 1, v);
    drv(1, 4'hF, 0);
    doRead(32'h0000_0010, 0, v);
    chk(v == 8'h12, "R2", "read after reset", v, 8'h12);

    repeat (2) drv(1, 4'hF, 0);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule